// File: doc/BRIEF.md
# Serial Controller Host Register File

This block is the byte-wide register interface that a host processor uses to program a classic PC-style serial port. The host puts a 3-bit offset on the bus with a read or write strobe. The block keeps the writable control state: interrupt enables, line format, modem control, a scratch byte and a 16-bit baud divisor. It feeds these settings to the transmitter and receiver as plain output wires.

The shifters and the interrupt identification logic live outside this block. Their bytes come in on simple input ports, and the block returns them on reads. A read of the data offset pops the receive byte with a one-cycle strobe. A write to the data offset pushes the written byte toward the transmitter with a one-cycle strobe.

A bank bit in the format register remaps offsets 0 and 1 onto the two divisor bytes. Offset 2 returns the identification byte on a read and discards a write.

Top module: `uart_regfile`

## Requirements
- R1: After reset the format, modem control, interrupt enable and scratch registers read 0, and every line and modem output is low.
- R2: A read of offset 0 with the bank bit clear returns `rx_byte`. Offset 2 returns `iid_byte`, offset 5 returns `lsr_byte` and offset 6 returns `msr_byte`.
- R3: When format bit 7 is set, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. The interrupt enable register is left untouched.
- R4: Format register fields drive the outputs: bits 1:0 drive `word_len` (3 selects 8 data bits), bit 2 drives `two_stop`, bit 3 drives `parity_en`, bit 4 drives `parity_even`, bit 5 drives `parity_stick` and bit 6 drives `break_on`. The whole byte reads back at offset 3.
- R5: Modem control at offset 4: bit 0 drives `dtr`, bit 1 drives `rts`, bit 2 drives `aux_ring`, bit 3 drives `irq_gate` and bit 4 drives `loopback`. Bits 7:5 are not stored and read as 0.
- R6: Offset 7 stores any byte and returns it unchanged, with no other effect.
- R7: `rx_pop` is high for exactly the cycle of a read of offset 0 with the bank bit clear, and never when the bank bit is set.
- R8: A write to offset 0 with the bank bit clear raises `tx_push` for that cycle with `tx_byte` equal to the written byte. A write with the bank bit set raises no push.
- R9: Writes to offsets 2, 5 and 6 change no register and raise no strobe.
- R10: Offset 1 with the bank bit clear holds a 4-bit interrupt enable. Bits 3:0 drive `int_en`, and bits 7:4 read as 0.
- R11: The divisor resets to the rounded quotient of REF_HZ over 16 times RESET_BAUD. With the defaults of 1843200 Hz and 9600 baud this is 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| rx_byte | input | 8 | Received byte from the receiver |
| iid_byte | input | 8 | Interrupt identification byte |
| lsr_byte | input | 8 | Line status byte |
| msr_byte | input | 8 | Modem status byte |
| rx_pop | output | 1 | Receive byte consumed |
| tx_push | output | 1 | Transmit byte offered |
| tx_byte | output | 8 | Byte offered to the transmitter |
| word_len | output | 2 | Data bit count code |
| two_stop | output | 1 | Two stop bits |
| parity_en | output | 1 | Parity enabled |
| parity_even | output | 1 | Even parity |
| parity_stick | output | 1 | Stuck parity |
| break_on | output | 1 | Drive continuous break |
| divisor | output | 16 | Baud divisor |
| dtr | output | 1 | Data terminal ready |
| rts | output | 1 | Request to send |
| aux_ring | output | 1 | Auxiliary ring output |
| irq_gate | output | 1 | Interrupt output gate |
| loopback | output | 1 | Internal loopback |
| int_en | output | 4 | Interrupt enables |

## Verification
A wrong bank decode shows up on the first divisor access. The written byte lands in the interrupt enables, or a pop or push strobe appears in the same cycle as the access. A register that latches on the wrong offset is visible one cycle after the write, through a line or modem output or through readback. Sweeping every byte value through each writable register exposes any field that is miswired or truncated on its next read.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 16;
  localparam int IER_W  = 4;
  localparam int MCR_W  = 5;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_IER  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_IID  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_FMT  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_MCR  = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_LSR  = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_MSR  = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_SCR  = 3'd7;

  localparam int BANK_BIT = 7;

  typedef struct packed {
    logic push;
    logic ier;
    logic fmt;
    logic mcr;
    logic scr;
    logic div_lo;
    logic div_hi;
  } rf_hits_t;

  // Rounded baud divisor: (ref + 8*baud - 1) / (16*baud)
  function automatic logic [DIV_W-1:0] calc_divisor(input longint ref_hz, input longint baud);
    longint q;
    q = (ref_hz + 8 * baud - 1) / (16 * baud);
    return q[DIV_W-1:0];
  endfunction
endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              bank,
  output rf_hits_t          hits,
  output logic              pop
);
  always_comb begin
    hits = '0;
    if (wr_en) begin
      unique case (addr)
        OFS_DATA: begin
          hits.push   = !bank;
          hits.div_lo = bank;
        end
        OFS_IER: begin
          hits.ier    = !bank;
          hits.div_hi = bank;
        end
        OFS_FMT: hits.fmt = 1'b1;
        OFS_MCR: hits.mcr = 1'b1;
        OFS_SCR: hits.scr = 1'b1;
        default: hits = '0;
      endcase
    end
  end

  assign pop = rd_en && (addr == OFS_DATA) && !bank;
endmodule

// File: rtl/uart_rf_store.sv
module uart_rf_store
  import uart_rf_pkg::*;
#(
  parameter logic [DIV_W-1:0] DIV_RESET = 16'd12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rf_hits_t          hits,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] fmt_q,
  output logic [MCR_W-1:0]  mcr_q,
  output logic [IER_W-1:0]  ier_q,
  output logic [BYTE_W-1:0] scr_q,
  output logic [DIV_W-1:0]  div_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q <= '0;
      mcr_q <= '0;
      ier_q <= '0;
      scr_q <= '0;
      div_q <= DIV_RESET;
    end else begin
      if (hits.fmt)    fmt_q <= wdata;
      if (hits.mcr)    mcr_q <= wdata[MCR_W-1:0];
      if (hits.ier)    ier_q <= wdata[IER_W-1:0];
      if (hits.scr)    scr_q <= wdata;
      if (hits.div_lo) div_q[BYTE_W-1:0] <= wdata;
      if (hits.div_hi) div_q[DIV_W-1:BYTE_W] <= wdata;
    end
  end
endmodule

// File: rtl/uart_rf_readmux.sv
module uart_rf_readmux
  import uart_rf_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              bank,
  input  logic [BYTE_W-1:0] fmt_q,
  input  logic [MCR_W-1:0]  mcr_q,
  input  logic [IER_W-1:0]  ier_q,
  input  logic [BYTE_W-1:0] scr_q,
  input  logic [DIV_W-1:0]  div_q,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] iid_byte,
  input  logic [BYTE_W-1:0] lsr_byte,
  input  logic [BYTE_W-1:0] msr_byte,
  output logic [BYTE_W-1:0] rdata
);
  always_comb begin
    unique case (addr)
      OFS_DATA: rdata = bank ? div_q[BYTE_W-1:0] : rx_byte;
      OFS_IER:  rdata = bank ? div_q[DIV_W-1:BYTE_W] : {{(BYTE_W-IER_W){1'b0}}, ier_q};
      OFS_IID:  rdata = iid_byte;
      OFS_FMT:  rdata = fmt_q;
      OFS_MCR:  rdata = {{(BYTE_W-MCR_W){1'b0}}, mcr_q};
      OFS_LSR:  rdata = lsr_byte;
      OFS_MSR:  rdata = msr_byte;
      default:  rdata = scr_q;
    endcase
  end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter longint REF_HZ     = 1843200,
  parameter longint RESET_BAUD = 9600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] iid_byte,
  input  logic [BYTE_W-1:0] lsr_byte,
  input  logic [BYTE_W-1:0] msr_byte,
  output logic              rx_pop,
  output logic              tx_push,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [1:0]        word_len,
  output logic              two_stop,
  output logic              parity_en,
  output logic              parity_even,
  output logic              parity_stick,
  output logic              break_on,
  output logic [DIV_W-1:0]  divisor,
  output logic              dtr,
  output logic              rts,
  output logic              aux_ring,
  output logic              irq_gate,
  output logic              loopback,
  output logic [IER_W-1:0]  int_en
);
  localparam logic [DIV_W-1:0] DIV_RESET = calc_divisor(REF_HZ, RESET_BAUD);

  rf_hits_t          hits;
  logic [BYTE_W-1:0] fmt_q;
  logic [MCR_W-1:0]  mcr_q;
  logic [IER_W-1:0]  ier_q;
  logic [BYTE_W-1:0] scr_q;
  logic [DIV_W-1:0]  div_q;
  logic              bank;

  assign bank = fmt_q[BANK_BIT];

  uart_rf_decode u_dec (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .bank(bank),
    .hits(hits), .pop(rx_pop)
  );

  uart_rf_store #(.DIV_RESET(DIV_RESET)) u_store (
    .clk(clk), .rst_n(rst_n), .hits(hits), .wdata(wdata),
    .fmt_q(fmt_q), .mcr_q(mcr_q), .ier_q(ier_q), .scr_q(scr_q), .div_q(div_q)
  );

  uart_rf_readmux u_rmux (
    .addr(addr), .bank(bank),
    .fmt_q(fmt_q), .mcr_q(mcr_q), .ier_q(ier_q), .scr_q(scr_q), .div_q(div_q),
    .rx_byte(rx_byte), .iid_byte(iid_byte), .lsr_byte(lsr_byte), .msr_byte(msr_byte),
    .rdata(rdata)
  );

  assign tx_push      = hits.push;
  assign tx_byte      = wdata;
  assign word_len     = fmt_q[1:0];
  assign two_stop     = fmt_q[2];
  assign parity_en    = fmt_q[3];
  assign parity_even  = fmt_q[4];
  assign parity_stick = fmt_q[5];
  assign break_on     = fmt_q[6];
  assign divisor      = div_q;
  assign dtr          = mcr_q[0];
  assign rts          = mcr_q[1];
  assign aux_ring     = mcr_q[2];
  assign irq_gate     = mcr_q[3];
  assign loopback     = mcr_q[4];
  assign int_en       = ier_q;
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk
  import uart_rf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [BYTE_W-1:0] wdata,
  input logic [BYTE_W-1:0] rdata,
  input logic [BYTE_W-1:0] rx_byte,
  input logic              rx_pop,
  input logic              tx_push,
  input logic [DIV_W-1:0]  divisor,
  input logic [BYTE_W-1:0] fmt_q,
  input logic [MCR_W-1:0]  mcr_q,
  input logic [IER_W-1:0]  ier_q,
  input logic [BYTE_W-1:0] scr_q
);
  // R7
  rx_pop_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> (rd_en && rdata == rx_byte));

  // R8
  push_keeps_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |=> $stable(divisor));

  // R8
  push_bank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> !fmt_q[BANK_BIT]);

  // R9
  ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == OFS_LSR || addr == OFS_MSR || addr == OFS_IID))
    |=> $stable({fmt_q, mcr_q, ier_q, scr_q, divisor}));

  // R3
  div_lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_DATA && fmt_q[BANK_BIT]) |=> divisor[BYTE_W-1:0] == $past(wdata));

  // R6
  scratch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_SCR) |=> scr_q == $past(wdata));
endmodule

bind uart_regfile uart_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .rx_byte(rx_byte), .rx_pop(rx_pop),
  .tx_push(tx_push), .divisor(divisor), .fmt_q(fmt_q), .mcr_q(mcr_q),
  .ier_q(ier_q), .scr_q(scr_q)
);

// File: tb/uart_regfile_test.sv
module uart_regfile_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] rx_byte = 8'hA5, iid_byte = 8'hC1, lsr_byte = 8'h60, msr_byte = 8'hB0;
  logic       rx_pop, tx_push;
  logic [7:0] tx_byte;
  logic [1:0] word_len;
  logic       two_stop, parity_en, parity_even, parity_stick, break_on;
  logic [15:0] divisor;
  logic       dtr, rts, aux_ring, irq_gate, loopback;
  logic [3:0] int_en;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_regfile uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rx_byte(rx_byte), .iid_byte(iid_byte),
    .lsr_byte(lsr_byte), .msr_byte(msr_byte), .rx_pop(rx_pop), .tx_push(tx_push),
    .tx_byte(tx_byte), .word_len(word_len), .two_stop(two_stop), .parity_en(parity_en),
    .parity_even(parity_even), .parity_stick(parity_stick), .break_on(break_on),
    .divisor(divisor), .dtr(dtr), .rts(rts), .aux_ring(aux_ring), .irq_gate(irq_gate),
    .loopback(loopback), .int_en(int_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  logic last_push;
  logic [7:0] last_txb;

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    #1;
    last_push = tx_push;
    last_txb  = tx_byte;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic pop);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1;
    d = rdata;
    pop = rx_pop;
    @(negedge clk);
    rd_en = 1'b0;
    #1;
    if (rx_pop) pop = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic p;
    int exp_div;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 / R11 reset state
    exp_div = $rtoi(1843200.0 / (16.0 * 9600.0) + 0.5);
    #1;
    check(divisor == 16'(exp_div), "R11 divisor reset", divisor, exp_div);
    check({dtr, rts, aux_ring, irq_gate, loopback} == 5'b0, "R1 modem outputs", {dtr, rts, aux_ring, irq_gate, loopback}, 0);
    check({break_on, parity_stick, parity_even, parity_en, two_stop, word_len} == 7'b0, "R1 format outputs",
          {break_on, parity_stick, parity_even, parity_en, two_stop, word_len}, 0);
    rd(3'd3, d, p); check(d == 8'h00, "R1 format read", d, 0);
    rd(3'd4, d, p); check(d == 8'h00, "R1 mcr read", d, 0);
    rd(3'd1, d, p); check(d == 8'h00, "R1 ier read", d, 0);
    rd(3'd7, d, p); check(d == 8'h00, "R1 scratch read", d, 0);

    // R2 read map
    rd(3'd0, d, p); check(d == rx_byte, "R2 data read", d, rx_byte);
    check(p == 1'b1, "R7 pop on data read", p, 1);
    rd(3'd2, d, p); check(d == iid_byte, "R2 iid read", d, iid_byte);
    check(p == 1'b0, "R7 no pop on iid read", p, 0);
    rd(3'd5, d, p); check(d == lsr_byte, "R2 lsr read", d, lsr_byte);
    rd(3'd6, d, p); check(d == msr_byte, "R2 msr read", d, msr_byte);

    // R6 scratch sweep
    for (int v = 0; v < 256; v++) begin
      wr(3'd7, 8'(v));
      rd(3'd7, d, p);
      check(d == 8'(v), "R6 scratch", d, v);
    end

    // R4 format sweep, bank clear
    for (int v = 0; v < 128; v++) begin
      wr(3'd3, 8'(v));
      #1;
      check({break_on, parity_stick, parity_even, parity_en, two_stop, word_len} == 7'(v),
            "R4 format fields", {break_on, parity_stick, parity_even, parity_en, two_stop, word_len}, v);
      rd(3'd3, d, p);
      check(d == 8'(v), "R4 format read", d, v);
    end
    wr(3'd3, 8'h03);
    #1; check(word_len == 2'd3, "R4 eight bits code", word_len, 3);

    // R5 modem control sweep
    for (int v = 0; v < 256; v++) begin
      wr(3'd4, 8'(v));
      #1;
      check({loopback, irq_gate, aux_ring, rts, dtr} == 5'(v % 32), "R5 modem outputs",
            {loopback, irq_gate, aux_ring, rts, dtr}, v % 32);
      rd(3'd4, d, p);
      check(d == 8'(v % 32), "R5 mcr read", d, v % 32);
    end

    // R10 interrupt enable sweep
    for (int v = 0; v < 256; v++) begin
      wr(3'd1, 8'(v));
      #1; check(int_en == 4'(v % 16), "R10 int_en", int_en, v % 16);
      rd(3'd1, d, p);
      check(d == 8'(v % 16), "R10 ier read", d, v % 16);
    end
    // int_en now 0xF

    // R8 push with bank clear
    wr(3'd0, 8'h5A);
    check(last_push == 1'b1, "R8 push strobe", last_push, 1);
    check(last_txb == 8'h5A, "R8 push byte", last_txb, 8'h5A);

    // R3 divisor bank
    for (int v = 0; v < 256; v += 17) begin
      wr(3'd3, 8'h83);
      wr(3'd0, 8'(v));
      check(last_push == 1'b0, "R8 no push in bank", last_push, 0);
      wr(3'd1, 8'(255 - v));
      #1;
      check(divisor == {8'(255 - v), 8'(v)}, "R3 divisor load", divisor, {8'(255 - v), 8'(v)});
      rd(3'd0, d, p);
      check(d == 8'(v), "R3 divisor low read", d, v);
      check(p == 1'b0, "R7 no pop in bank", p, 0);
      rd(3'd1, d, p);
      check(d == 8'(255 - v), "R3 divisor high read", d, 255 - v);
      wr(3'd3, 8'h03);
      #1; check(int_en == 4'hF, "R3 ier untouched", int_en, 15);
      rd(3'd0, d, p);
      check(d == rx_byte, "R3 data restored", d, rx_byte);
    end

    // R9 ignored writes
    wr(3'd7, 8'h3C);
    wr(3'd4, 8'h15);
    wr(3'd3, 8'h83); wr(3'd0, 8'h21); wr(3'd1, 8'h43); wr(3'd3, 8'h1B);
    for (int k = 0; k < 3; k++) begin
      logic [2:0] a;
      a = (k == 0) ? 3'd2 : (k == 1) ? 3'd5 : 3'd6;
      wr(a, 8'hFF);
      check(last_push == 1'b0, "R9 no push", last_push, 0);
      rd(3'd7, d, p); check(d == 8'h3C, "R9 scratch kept", d, 8'h3C);
      rd(3'd4, d, p); check(d == 8'h15, "R9 mcr kept", d, 8'h15);
      rd(3'd3, d, p); check(d == 8'h1B, "R9 format kept", d, 8'h1B);
      rd(3'd1, d, p); check(d == 8'h0F, "R9 ier kept", d, 8'h0F);
      #1; check(divisor == 16'h4321, "R9 divisor kept", divisor, 16'h4321);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule